// File: doc/BRIEF.md
# CCD Front-End Pixel Timing Sequencer

This block is the digital timing core of a three-channel (red, green, blue) CCD front end. It runs from one master clock and watches a one-clock, active-high pixel sync pulse. From these it generates the video and reset sample-and-hold strobes, the select code for the analogue input multiplexer, the ADC convert strobe and a per-word valid flag. The valid flag is delayed so that it lines up with the converted data words.

Six operating modes set how many clocks make up one pixel and which converted words carry data. The modes are colour, standard monochrome, fast monochrome, max-speed monochrome, slow colour and slow monochrome. A separate input picks the channel used by the monochrome modes. A 2-bit gap field places the reset sample relative to the video sample. All configuration is sampled on a sync pulse and then held for the whole pixel. A sync pulse that arrives off the expected spacing restarts the sequence and sets a sticky error flag.

Top module: `ccd_seq_top`

## Requirements
- R1: While reset is asserted and afterwards until the first sync pulse is sampled, every strobe, `word_vld` and `sync_err` stay low. The held mode resets to colour with CDS on.
- R2: A sync pulse sampled on a rising edge restarts the pixel at phase 0, and `vid_smp` is high for the clock after that edge. Without further syncs the phase counts 0 to N-1 and wraps, with N = 6 in colour and standard monochrome, 3 in fast monochrome, 2 in max-speed monochrome and 8 in both slow modes.
- R3: Colour mode (`mode_sel` 0, also 6 and 7) converts at phases 0, 2 and 4. `chan_sel` is 0 (red), 1 (green) and 2 (blue) for those words in that order, and all three words are valid.
- R4: Standard monochrome (`mode_sel` 1) keeps the colour timing, but `chan_sel` holds the held channel (`mono_chan` 3 selects 2). Only the word converted at phase 0 is valid.
- R5: Fast monochrome (`mode_sel` 2) converts only at phase 0, and that word is valid. With CDS on, `rst_smp` fires at phase 2 whatever `cds_gap` holds.
- R6: Max-speed monochrome (`mode_sel` 3) converts at phase 0 with every word valid, and `rst_smp` never fires even when `cds_on` is 1.
- R7: Slow colour (`mode_sel` 4) converts at phases 0, 2, 4 and 6 with `chan_sel` 0, 1, 2, 2. The first three words are valid.
- R8: Slow monochrome (`mode_sel` 5) converts at phases 0, 2, 4 and 6 on the held channel. Only the first word is valid.
- R9: In modes with N of 6 or 8 and CDS held on, `rst_smp` fires at phase `cds_gap`+2, so gap value 2 places it 4 clocks after the video sample. With CDS held off it never fires.
- R10: A sync sampled while running at any phase other than N-1 sets `sync_err` from the next clock. The flag then stays set until `err_clr` is sampled high with no new mismatch, which has priority.
- R11: `word_vld` equals the word-valid condition of the clock exactly PIPE_DEPTH clocks earlier.
- R12: Changes on `mode_sel`, `mono_chan`, `cds_on` and `cds_gap` between sync pulses do not alter any output until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_sync | input | 1 | Active-high pixel sync pulse |
| mode_sel | input | 3 | Operating mode code |
| mono_chan | input | 2 | Channel for monochrome modes (0 R, 1 G, 2/3 B) |
| cds_on | input | 1 | Enable reset-level sampling |
| cds_gap | input | 2 | Reset sample offset code |
| err_clr | input | 1 | Clear the sticky sync error |
| vid_smp | output | 1 | Video sample-and-hold strobe |
| rst_smp | output | 1 | Reset-level sample-and-hold strobe |
| chan_sel | output | 2 | Analogue multiplexer select |
| adc_go | output | 1 | ADC convert strobe |
| word_vld | output | 1 | Output word valid, pipeline aligned |
| sync_err | output | 1 | Sticky sync spacing error |

## Verification
The assertions assume that every input is synchronous to `clk`, changes well away from its rising edge and holds a defined level from reset release on. They place no limit on sync spacing, because a mismatch is a defined case that the error flag covers. The stimulus drives all inputs only on the falling edge and raises `pix_sync` for exactly one clock per pixel. It keeps configuration constant except where a scenario changes it on purpose in the middle of a pixel.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  localparam int PH_W = 4;

  typedef enum logic [2:0] {
    M_COLOUR   = 3'd0,
    M_MONO     = 3'd1,
    M_FASTMONO = 3'd2,
    M_MAXMONO  = 3'd3,
    M_SLOWCOL  = 3'd4,
    M_SLOWMONO = 3'd5,
    M_RSV6     = 3'd6,
    M_RSV7     = 3'd7
  } mode_e;

  // clocks per pixel for each mode
  function automatic logic [PH_W-1:0] ratio_of(mode_e m);
    case (m)
      M_FASTMONO:           ratio_of = PH_W'(3);
      M_MAXMONO:            ratio_of = PH_W'(2);
      M_SLOWCOL, M_SLOWMONO: ratio_of = PH_W'(8);
      default:              ratio_of = PH_W'(6);
    endcase
  endfunction

  function automatic logic is_colour(mode_e m);
    is_colour = (m == M_COLOUR) || (m == M_SLOWCOL) || (m == M_RSV6) || (m == M_RSV7);
  endfunction

  function automatic logic first_word_only(mode_e m);
    first_word_only = (m == M_MONO) || (m == M_SLOWMONO);
  endfunction

endpackage

// File: rtl/ccd_phase_ctr.sv
module ccd_phase_ctr
  import ccd_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_i,
  input  logic [2:0]      cfg_mode,
  input  logic [1:0]      cfg_ch,
  input  logic            cfg_cds,
  input  logic [1:0]      cfg_gap,
  input  logic            err_clr,
  output logic [PH_W-1:0] phase_o,
  output logic            run_o,
  output mode_e           mode_o,
  output logic [1:0]      ch_o,
  output logic            cds_o,
  output logic [1:0]      gap_o,
  output logic            err_o
);

  logic [PH_W-1:0] phase_q, phase_d, lim;
  logic            run_q, run_d, cds_q, cds_d, err_q, err_d, at_end;
  mode_e           mode_q, mode_d, mode_in;
  logic [1:0]      ch_q, ch_d, gap_q, gap_d;

  always_comb begin
    mode_in = mode_e'(cfg_mode);
    lim     = ratio_of(mode_q) - PH_W'(1);
    at_end  = (phase_q == lim);
    phase_d = phase_q;
    run_d   = run_q;
    mode_d  = mode_q;
    ch_d    = ch_q;
    cds_d   = cds_q;
    gap_d   = gap_q;
    if (sync_i) begin
      phase_d = '0;
      run_d   = 1'b1;
      mode_d  = mode_in;
      ch_d    = cfg_ch;
      cds_d   = cfg_cds && (mode_in != M_MAXMONO);
      gap_d   = cfg_gap;
    end else if (run_q) begin
      phase_d = at_end ? '0 : phase_q + PH_W'(1);
    end
    if (sync_i && run_q && !at_end) err_d = 1'b1;
    else if (err_clr)               err_d = 1'b0;
    else                            err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      run_q   <= 1'b0;
      mode_q  <= M_COLOUR;
      ch_q    <= 2'd0;
      cds_q   <= 1'b1;
      gap_q   <= 2'd0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      run_q   <= run_d;
      mode_q  <= mode_d;
      ch_q    <= ch_d;
      cds_q   <= cds_d;
      gap_q   <= gap_d;
      err_q   <= err_d;
    end
  end

  assign phase_o = phase_q;
  assign run_o   = run_q;
  assign mode_o  = mode_q;
  assign ch_o    = ch_q;
  assign cds_o   = cds_q;
  assign gap_o   = gap_q;
  assign err_o   = err_q;

  // R2
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (phase_q < ratio_of(mode_q)));

  // R2
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (phase_q == '0) && run_q);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> $stable(mode_q) && $stable(ch_q) && $stable(gap_q));

endmodule

// File: rtl/ccd_strobe_dec.sv
module ccd_strobe_dec
  import ccd_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase_i,
  input  logic            run_i,
  input  mode_e           mode_i,
  input  logic [1:0]      ch_i,
  input  logic            cds_i,
  input  logic [1:0]      gap_i,
  output logic            vid_o,
  output logic            rst_o,
  output logic            conv_o,
  output logic [1:0]      mux_o,
  output logic            raw_vld_o
);

  logic [PH_W-2:0] word_idx;
  logic [PH_W-1:0] rst_pos;

  always_comb begin
    word_idx = phase_i[PH_W-1:1];
    rst_pos  = (mode_i == M_FASTMONO) ? PH_W'(2) : PH_W'(gap_i) + PH_W'(2);
    vid_o    = run_i && (phase_i == '0);
    rst_o    = run_i && cds_i && (phase_i == rst_pos);
    conv_o   = run_i && ((mode_i == M_FASTMONO) ? (phase_i == '0) : !phase_i[0]);
    if (is_colour(mode_i))
      mux_o = (word_idx >= (PH_W-1)'(2)) ? 2'd2 : word_idx[1:0];
    else
      mux_o = (ch_i == 2'd3) ? 2'd2 : ch_i;
    if (first_word_only(mode_i))
      raw_vld_o = conv_o && (word_idx == '0);
    else if (is_colour(mode_i))
      raw_vld_o = conv_o && (word_idx < (PH_W-1)'(3));
    else
      raw_vld_o = conv_o;
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_o && rst_o));

  // R6
  maxspeed_nocds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_MAXMONO) |-> !rst_o);

endmodule

// File: rtl/ccd_valid_pipe.sv
module ccd_valid_pipe #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic vld_o
);

  logic [DEPTH-1:0] sr_q, sr_d;

  generate
    if (DEPTH == 1) begin : g_one
      always_comb sr_d = raw_i;
    end else begin : g_many
      always_comb sr_d = {sr_q[DEPTH-2:0], raw_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign vld_o = sr_q[DEPTH-1];

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top
  import ccd_seq_pkg::*;
#(
  parameter int PIPE_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_sync,
  input  logic [2:0] mode_sel,
  input  logic [1:0] mono_chan,
  input  logic       cds_on,
  input  logic [1:0] cds_gap,
  input  logic       err_clr,
  output logic       vid_smp,
  output logic       rst_smp,
  output logic [1:0] chan_sel,
  output logic       adc_go,
  output logic       word_vld,
  output logic       sync_err
);

  logic [PH_W-1:0] phase;
  logic            running, cds_hold, raw_vld;
  mode_e           mode_hold;
  logic [1:0]      ch_hold, gap_hold;

  ccd_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .sync_i(pix_sync),
    .cfg_mode(mode_sel), .cfg_ch(mono_chan), .cfg_cds(cds_on), .cfg_gap(cds_gap),
    .err_clr(err_clr),
    .phase_o(phase), .run_o(running), .mode_o(mode_hold), .ch_o(ch_hold),
    .cds_o(cds_hold), .gap_o(gap_hold), .err_o(sync_err)
  );

  ccd_strobe_dec u_dec (
    .clk(clk), .rst_n(rst_n),
    .phase_i(phase), .run_i(running), .mode_i(mode_hold), .ch_i(ch_hold),
    .cds_i(cds_hold), .gap_i(gap_hold),
    .vid_o(vid_smp), .rst_o(rst_smp), .conv_o(adc_go), .mux_o(chan_sel),
    .raw_vld_o(raw_vld)
  );

  ccd_valid_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_vld), .vld_o(word_vld)
  );

endmodule

// File: tb/sim_ccd_seq_top.sv
module sim_ccd_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n, pix_sync, cds_on, err_clr;
  logic [2:0] mode_sel;
  logic [1:0] mono_chan, cds_gap;
  logic vid_smp, rst_smp, adc_go, word_vld, sync_err;
  logic [1:0] chan_sel;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // bench model state
  int m_phase, m_mode, m_ch, m_gap;
  bit m_run, m_cds, m_err;
  bit [D-1:0] hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_seq_top #(.PIPE_DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_sync(pix_sync), .mode_sel(mode_sel),
    .mono_chan(mono_chan), .cds_on(cds_on), .cds_gap(cds_gap), .err_clr(err_clr),
    .vid_smp(vid_smp), .rst_smp(rst_smp), .chan_sel(chan_sel), .adc_go(adc_go),
    .word_vld(word_vld), .sync_err(sync_err)
  );

  function automatic int ratio(int m);
    if (m == 2) return 3;
    if (m == 3) return 2;
    if (m == 4 || m == 5) return 8;
    return 6;
  endfunction

  function automatic bit colour(int m);
    return (m == 0 || m == 4 || m == 6 || m == 7);
  endfunction

  function automatic bit e_conv();
    if (!m_run) return 1'b0;
    if (m_mode == 2) return m_phase == 0;
    return (m_phase % 2) == 0;
  endfunction

  function automatic bit e_raw();
    int idx = m_phase / 2;
    if (!e_conv()) return 1'b0;
    if (m_mode == 1 || m_mode == 5) return idx == 0;
    if (colour(m_mode)) return idx < 3;
    return 1'b1;
  endfunction

  function automatic int e_mux();
    int idx = m_phase / 2;
    if (colour(m_mode)) return (idx > 2) ? 2 : idx;
    return (m_ch == 3) ? 2 : m_ch;
  endfunction

  function automatic bit e_rst();
    int pos = (m_mode == 2) ? 2 : m_gap + 2;
    return m_run && m_cds && (m_phase == pos);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk((m_run ? "R2" : "R1"), "vid_smp", int'(vid_smp), int'(m_run && m_phase == 0));
    chk(cur_req, "adc_go", int'(adc_go), int'(e_conv()));
    chk(cur_req, "rst_smp", int'(rst_smp), int'(e_rst()));
    if (e_conv()) chk(cur_req, "chan_sel", int'(chan_sel), e_mux());
    chk("R11", "word_vld", int'(word_vld), int'(hist[D-1]));
    chk("R10", "sync_err", int'(sync_err), int'(m_err));
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    hist = {hist[D-2:0], e_raw()};
    if (pix_sync && m_run && m_phase != ratio(m_mode) - 1) m_err = 1'b1;
    else if (err_clr) m_err = 1'b0;
    if (pix_sync) begin
      m_phase = 0; m_run = 1'b1; m_mode = int'(mode_sel); m_ch = int'(mono_chan);
      m_gap = int'(cds_gap); m_cds = cds_on && (mode_sel != 3'd3);
    end else if (m_run) begin
      m_phase = (m_phase == ratio(m_mode) - 1) ? 0 : m_phase + 1;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic run_pixels(int mode, int ch, bit cds, int gap, int npix);
    for (int p = 0; p < npix; p++) begin
      mode_sel = 3'(mode); mono_chan = 2'(ch); cds_on = cds; cds_gap = 2'(gap);
      pix_sync = 1'b1;
      step();
      pix_sync = 1'b0;
      for (int k = 1; k < ratio(mode); k++) step();
    end
  endtask

  task automatic clear_err();
    err_clr = 1'b1; step(); err_clr = 1'b0;
  endtask

  task automatic t_reset();
    cur_req = "R1";
    rst_n = 1'b0; pix_sync = 1'b0; mode_sel = 3'd0; mono_chan = 2'd0;
    cds_on = 1'b1; cds_gap = 2'd0; err_clr = 1'b0;
    m_phase = 0; m_run = 1'b0; m_mode = 0; m_ch = 0; m_gap = 0; m_cds = 1'b1;
    m_err = 1'b0; hist = '0;
    repeat (2) @(negedge clk);
    compare();
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) step();
  endtask

  task automatic t_colour();
    cur_req = "R3";
    run_pixels(0, 0, 1'b1, 2, 3);
    run_pixels(7, 1, 1'b1, 2, 2);
    clear_err();
  endtask

  task automatic t_mono();
    cur_req = "R4";
    run_pixels(1, 1, 1'b1, 1, 2);
    run_pixels(1, 3, 1'b1, 1, 2);
    clear_err();
  endtask

  task automatic t_fast();
    cur_req = "R5";
    run_pixels(2, 0, 1'b1, 0, 4);
    run_pixels(2, 2, 1'b1, 3, 3);
    clear_err();
  endtask

  task automatic t_max();
    cur_req = "R6";
    run_pixels(3, 1, 1'b1, 2, 5);
    clear_err();
  endtask

  task automatic t_slow_colour();
    cur_req = "R7";
    run_pixels(4, 0, 1'b1, 2, 3);
    clear_err();
  endtask

  task automatic t_slow_mono();
    cur_req = "R8";
    run_pixels(5, 2, 1'b1, 2, 3);
    clear_err();
  endtask

  task automatic t_gap();
    cur_req = "R9";
    run_pixels(0, 0, 1'b1, 0, 2);
    run_pixels(0, 0, 1'b1, 1, 2);
    run_pixels(0, 0, 1'b1, 3, 2);
    run_pixels(4, 0, 1'b1, 2, 2);
    run_pixels(0, 0, 1'b0, 2, 2);
    clear_err();
  endtask

  task automatic t_sync_err();
    cur_req = "R10";
    run_pixels(0, 0, 1'b1, 0, 2);
    clear_err();
    pix_sync = 1'b1; step(); pix_sync = 1'b0;
    step(); step();
    pix_sync = 1'b1; step(); pix_sync = 1'b0;   // early sync: mismatch
    for (int k = 0; k < 8; k++) step();
    chk("R10", "sticky flag", int'(sync_err), 1);
    clear_err();
    chk("R10", "flag after clear", int'(sync_err), 0);
    for (int k = 0; k < 4; k++) step();
  endtask

  task automatic t_change();
    cur_req = "R12";
    run_pixels(0, 0, 1'b1, 2, 1);
    clear_err();
    pix_sync = 1'b1; mode_sel = 3'd0; step(); pix_sync = 1'b0;
    mode_sel = 3'd3; mono_chan = 2'd1; cds_on = 1'b0; cds_gap = 2'd0;
    for (int k = 0; k < 11; k++) step();
    pix_sync = 1'b1; step(); pix_sync = 1'b0;   // new mode now takes effect
    for (int k = 0; k < 6; k++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_colour();
    t_mono();
    t_fast();
    t_max();
    t_slow_colour();
    t_slow_mono();
    t_gap();
    t_sync_err();
    t_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule